// File: doc/BRIEF.md
# ECC-Aligned Write Coalescing Buffer

This block sits between a byte-serial download path and a RAM whose contents are protected by a 64-bit error-correcting code. Such a RAM cannot accept a narrower write to an uninitialised location without corrupting its check bits. The block takes a start address and a total byte count, then accepts the payload one byte at a time. Each byte goes into the lane of an eight-byte staging word that matches its address. Memory only ever sees complete, eight-byte-aligned 64-bit writes.

When the first byte lands partway into a doubleword, the lanes below it go out as zero. When the last byte leaves the final doubleword partly filled, the lanes above it go out as zero. Because of this zero padding, every write is full width, including the first and last. The write port uses a valid/ready handshake. While a completed word waits for the memory, the byte source is stalled. A one-cycle done pulse marks the acceptance of the last word. A start address that is not four-byte aligned is refused, and a sticky error flag is raised.

Top module: `ecc_wr_coalesce`

## Requirements
- R1: Every write presents an address whose low three bits are zero. Within one transfer, the first write goes to the start address rounded down to a multiple of 8, and each later write goes to the previous address plus 8.
- R2: Byte lane n of `wr_data_o` (bits 8n+7 down to 8n) holds the byte destined for address `wr_addr_o + n`. The k-th accepted byte (k counted from 0) is destined for start address + k.
- R3: Lanes whose address lies below the start address, in the first doubleword of a transfer, are written as 0x00.
- R4: Lanes whose address lies at or beyond start address + byte count, in the last doubleword of a transfer, are written as 0x00.
- R5: A transfer accepts exactly `byte_count_i` bytes. It issues exactly ((start mod 8) + count + 7) / 8 writes, one write for each doubleword that has been filled or closed by the end of the stream.
- R6: While `wr_valid_o` is high and `wr_ready_i` is low, `byte_ready_o` is low and the pending address and data stay unchanged into the next cycle.
- R7: `done_o` is high for exactly one cycle: the cycle after the handshake that accepts the final write of a transfer.
- R8: A start request whose address is not a multiple of 4 sets `err_o`. After that request, no byte is accepted and no write is issued. `err_o` stays high until reset.
- R9: A start request made while a transfer is in progress is ignored. A start request with a byte count of zero issues no write and raises `done_o` in the next cycle.
- R10: After reset, `wr_valid_o`, `byte_ready_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse, honoured only when idle |
| start_addr_i | input | AW | Byte address of the first payload byte |
| byte_count_i | input | CW | Number of payload bytes in the transfer |
| byte_valid_i | input | 1 | Payload byte available |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Block takes the byte in this cycle when valid is high |
| wr_valid_o | output | 1 | Write request pending |
| wr_addr_o | output | AW | Aligned doubleword address of the write |
| wr_data_o | output | 8*LANES | Full-width write data, lowest address in the least significant byte |
| wr_ready_i | input | 1 | Memory accepts the pending write |
| done_o | output | 1 | One-cycle pulse after the final write is accepted |
| err_o | output | 1 | Sticky flag for a start address that is not four-byte aligned |

## Verification
On every cycle, the assertions check write address alignment, the stall rule and the holding of a pending write, the single-cycle width of the done pulse, and the stickiness of the error flag. Which bytes land in which lanes, the zero padding at the head and tail, and the exact number of writes and bytes all depend on the whole transfer. Only the bench's sweeps over start offsets, byte counts and handshake patterns can show these, against an arithmetic model of the target memory image. Ignored restarts, zero-length transfers and refused misaligned starts are likewise shown by directed scenarios.

// File: rtl/ecc_wc_pkg.sv
package ecc_wc_pkg;

    localparam int unsigned WC_BYTE_W     = 8;
    localparam int unsigned WC_ADDR_W     = 32;
    localparam int unsigned WC_COUNT_W    = 16;
    localparam int unsigned WC_LANES      = 8;
    localparam int unsigned WC_HEAD_ALIGN = 4;

    typedef enum logic [1:0] {
        WC_IDLE  = 2'd0,
        WC_FILL  = 2'd1,
        WC_DRAIN = 2'd2
    } wc_state_e;

    typedef logic [WC_BYTE_W-1:0] wc_byte_t;

endpackage

// File: rtl/ecc_wc_ctrl.sv
module ecc_wc_ctrl
    import ecc_wc_pkg::*;
#(
    parameter int unsigned AW         = WC_ADDR_W,
    parameter int unsigned CW         = WC_COUNT_W,
    parameter int unsigned LANES      = WC_LANES,
    parameter int unsigned HEAD_ALIGN = WC_HEAD_ALIGN,
    localparam int unsigned LB        = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [CW-1:0] byte_count_i,
    input  logic          byte_valid_i,
    input  logic          slot_free_i,
    input  logic          wr_fire_i,
    output logic          byte_ready_o,
    output logic          take_o,
    output logic          flush_o,
    output logic          arm_o,
    output logic [LB-1:0] lane_o,
    output logic [AW-1:0] base_o,
    output logic          done_o,
    output logic          err_o
);

    wc_state_e     state_q;
    logic [LB-1:0] lane_q;
    logic [AW-1:0] base_q;
    logic [CW-1:0] left_q;
    logic          done_q;
    logic          err_q;

    logic          misaligned;
    logic          last_byte;
    logic          lane_full;
    logic [AW-1:0] aligned_start;

    always_comb begin
        misaligned    = (start_addr_i % AW'(HEAD_ALIGN)) != '0;
        aligned_start = start_addr_i & ~AW'(LANES - 1);
        last_byte     = (left_q == CW'(1));
        lane_full     = (lane_q == LB'(LANES - 1));
        byte_ready_o  = (state_q == WC_FILL) && slot_free_i;
        take_o        = byte_ready_o && byte_valid_i;
        flush_o       = take_o && (lane_full || last_byte);
        arm_o         = (state_q == WC_IDLE) && start_i && !misaligned
                        && (byte_count_i != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WC_IDLE;
            lane_q  <= '0;
            base_q  <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                WC_IDLE: begin
                    if (start_i) begin
                        if (misaligned) begin
                            err_q <= 1'b1;
                        end else if (byte_count_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            base_q  <= aligned_start;
                            lane_q  <= start_addr_i[LB-1:0];
                            left_q  <= byte_count_i;
                            state_q <= WC_FILL;
                        end
                    end
                end
                WC_FILL: begin
                    if (take_o) begin
                        left_q <= left_q - CW'(1);
                        if (flush_o) begin
                            lane_q <= '0;
                            base_q <= base_q + AW'(LANES);
                            if (last_byte) begin
                                state_q <= WC_DRAIN;
                            end
                        end else begin
                            lane_q <= lane_q + LB'(1);
                        end
                    end
                end
                WC_DRAIN: begin
                    if (wr_fire_i) begin
                        state_q <= WC_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= WC_IDLE;
            endcase
        end
    end

    assign lane_o = lane_q;
    assign base_o = base_q;
    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/ecc_wc_lanes.sv
module ecc_wc_lanes
    import ecc_wc_pkg::*;
#(
    parameter int unsigned LANES = WC_LANES,
    localparam int unsigned LB   = $clog2(LANES),
    localparam int unsigned DW   = LANES * WC_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          take_i,
    input  logic [LB-1:0] lane_i,
    input  wc_byte_t      byte_i,
    output logic [DW-1:0] merged_o
);

    wc_byte_t stage_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = take_i && (lane_i == LB'(g));

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                stage_q[g] <= '0;
            end else if (hit) begin
                stage_q[g] <= byte_i;
            end
        end

        assign merged_o[g*WC_BYTE_W +: WC_BYTE_W] = hit ? byte_i : stage_q[g];
    end

endmodule

// File: rtl/ecc_wc_wport.sv
module ecc_wc_wport
    import ecc_wc_pkg::*;
#(
    parameter int unsigned AW    = WC_ADDR_W,
    parameter int unsigned LANES = WC_LANES,
    localparam int unsigned DW   = LANES * WC_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          wr_ready_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } word_t;

    word_t word_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (load_i) begin
            valid_q     <= 1'b1;
            word_q.addr <= addr_i;
            word_q.data <= data_i;
        end else if (valid_q && wr_ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign wr_valid_o = valid_q;
    assign wr_addr_o  = word_q.addr;
    assign wr_data_o  = word_q.data;

endmodule

// File: rtl/ecc_wr_coalesce.sv
module ecc_wr_coalesce
    import ecc_wc_pkg::*;
#(
    parameter int unsigned AW         = WC_ADDR_W,
    parameter int unsigned CW         = WC_COUNT_W,
    parameter int unsigned LANES      = WC_LANES,
    parameter int unsigned HEAD_ALIGN = WC_HEAD_ALIGN,
    localparam int unsigned LB        = $clog2(LANES),
    localparam int unsigned DW        = LANES * WC_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [CW-1:0] byte_count_i,
    input  logic          byte_valid_i,
    input  logic [7:0]    byte_data_i,
    output logic          byte_ready_o,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ready_i,
    output logic          done_o,
    output logic          err_o
);

    logic          slot_free;
    logic          wr_fire;
    logic          take;
    logic          flush;
    logic          arm;
    logic [LB-1:0] lane;
    logic [AW-1:0] base;
    logic [DW-1:0] merged;

    assign slot_free = !wr_valid_o || wr_ready_i;
    assign wr_fire   = wr_valid_o && wr_ready_i;

    ecc_wc_ctrl #(
        .AW(AW), .CW(CW), .LANES(LANES), .HEAD_ALIGN(HEAD_ALIGN)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .byte_count_i (byte_count_i),
        .byte_valid_i (byte_valid_i),
        .slot_free_i  (slot_free),
        .wr_fire_i    (wr_fire),
        .byte_ready_o (byte_ready_o),
        .take_o       (take),
        .flush_o      (flush),
        .arm_o        (arm),
        .lane_o       (lane),
        .base_o       (base),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    ecc_wc_lanes #(.LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (arm || flush),
        .take_i   (take),
        .lane_i   (lane),
        .byte_i   (byte_data_i),
        .merged_o (merged)
    );

    ecc_wc_wport #(.AW(AW), .LANES(LANES)) u_wport (
        .clk        (clk),
        .rst        (rst),
        .load_i     (flush),
        .addr_i     (base),
        .data_i     (merged),
        .wr_ready_i (wr_ready_i),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );

endmodule

// File: rtl/ecc_wc_checker.sv
module ecc_wc_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned LANES = 8,
    localparam int unsigned DW   = LANES * 8
) (
    input logic          clk,
    input logic          rst,
    input logic          byte_ready_o,
    input logic          wr_valid_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [DW-1:0] wr_data_o,
    input logic          wr_ready_i,
    input logic          done_o,
    input logic          err_o
);

    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> ((wr_addr_o % AW'(LANES)) == '0));

    assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |-> !byte_ready_o);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

endmodule

bind ecc_wr_coalesce ecc_wc_checker #(.AW(AW), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_ready_o (byte_ready_o),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .wr_ready_i   (wr_ready_i),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/ecc_wr_coalesce_tb.sv
`timescale 1ns/1ps
module ecc_wr_coalesce_tb;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int LANES = 8;
    localparam int DW = LANES * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [CW-1:0] byte_count_i = '0;
    logic          byte_valid_i = 1'b0;
    logic [7:0]    byte_data_i = '0;
    logic          byte_ready_o;
    logic          wr_valid_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic          wr_ready_i = 1'b0;
    logic          done_o;
    logic          err_o;

    int checks = 0;
    int errors = 0;
    int run_id = 0;
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    ecc_wr_coalesce #(.AW(AW), .CW(CW), .LANES(LANES)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_count_i(byte_count_i), .byte_valid_i(byte_valid_i),
        .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ready_i(wr_ready_i), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (run %0d)", tag, act, exp, run_id);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    function automatic logic [7:0] pat(input int run, input int i);
        return 8'((i * 29 + run * 7 + 3) & 255);
    endfunction

    task automatic run_xfer(input logic [AW-1:0] addr, input int cnt,
                            input int mode, input bit inject);
        int sent = 0;
        int writes = 0;
        int exp_writes;
        int cyc = 0;
        bit pend_done = 0;
        bit finished = 0;
        bit prev_stall = 0;
        logic [AW-1:0] prev_addr = '0;
        logic [DW-1:0] prev_data = '0;
        logic [AW-1:0] exp_addr;
        string ctag;
        exp_writes = (int'(addr % 8) + cnt + 7) / 8;
        exp_addr = addr & ~AW'(7);
        start_i = 1'b1;
        start_addr_i = addr;
        byte_count_i = CW'(cnt);
        step();
        start_i = 1'b0;
        while (!finished && cyc < 400) begin
            byte_valid_i = (sent < cnt) && (mode != 2 || lfsr[0]);
            byte_data_i = pat(run_id, sent);
            wr_ready_i = (mode != 1) || lfsr[1];
            if (inject && cyc == 3) begin
                start_i = 1'b1;
                start_addr_i = addr + 64;
                byte_count_i = CW'(5);
            end
            #1;
            if (pend_done) begin
                chk(done_o == 1'b1, "R7 done after final write", 64'(done_o), 64'd1);
                finished = 1;
            end else if (done_o) begin
                chk(1'b0, "R7 early done", 64'(done_o), 64'd0);
            end
            if (prev_stall) begin
                chk(wr_valid_o && wr_addr_o == prev_addr && wr_data_o == prev_data,
                    "R6 pending write held", wr_data_o, prev_data);
            end
            if (wr_valid_o && !wr_ready_i) begin
                chk(byte_ready_o == 1'b0, "R6 stall while pending", 64'(byte_ready_o), 64'd0);
            end
            prev_stall = wr_valid_o && !wr_ready_i;
            prev_addr = wr_addr_o;
            prev_data = wr_data_o;
            if (byte_valid_i && byte_ready_o) sent++;
            if (wr_valid_o && wr_ready_i) begin
                chk(wr_addr_o == exp_addr, "R1 write address", 64'(wr_addr_o), 64'(exp_addr));
                for (int n = 0; n < LANES; n++) begin
                    logic [AW-1:0] a;
                    logic [7:0] eb;
                    string t;
                    a = exp_addr + AW'(n);
                    if (a < addr) begin
                        eb = 8'h00; t = "R3 head zero lane";
                    end else if (a >= addr + AW'(cnt)) begin
                        eb = 8'h00; t = "R4 tail zero lane";
                    end else begin
                        eb = pat(run_id, int'(a - addr)); t = "R2 data lane";
                    end
                    chk(wr_data_o[n*8 +: 8] == eb, t, 64'(wr_data_o[n*8 +: 8]), 64'(eb));
                end
                exp_addr = exp_addr + AW'(8);
                writes++;
                if (writes == exp_writes) pend_done = 1;
            end
            step();
            start_i = 1'b0;
            cyc++;
        end
        byte_valid_i = 1'b0;
        wr_ready_i = 1'b0;
        ctag = inject ? "R9 restart ignored, write count" : "R5 write count";
        chk(writes == exp_writes, ctag, 64'(writes), 64'(exp_writes));
        chk(sent == cnt, "R5 bytes accepted", 64'(sent), 64'(cnt));
        chk(finished, "R7 transfer completed with done", 64'(finished), 64'd1);
        #1;
        chk(done_o == 1'b0 && wr_valid_o == 1'b0, "R7 done single cycle",
            64'(done_o), 64'd0);
        step();
        run_id++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step();
        chk(!wr_valid_o && !byte_ready_o && !done_o && !err_o, "R10 reset state",
            {60'd0, wr_valid_o, byte_ready_o, done_o, err_o}, 64'd0);

        for (int off = 0; off < 8; off += 4) begin
            for (int cnt = 1; cnt <= 17; cnt++) begin
                for (int mode = 0; mode < 3; mode++) begin
                    run_xfer(32'h2000_0000 + AW'(run_id * 64 + off), cnt, mode,
                             cnt == 15);
                end
            end
        end

        // R9: zero-length transfer
        start_i = 1'b1;
        start_addr_i = 32'h0000_0040;
        byte_count_i = '0;
        step();
        start_i = 1'b0;
        chk(done_o == 1'b1, "R9 zero count done", 64'(done_o), 64'd1);
        step();
        chk(done_o == 1'b0 && wr_valid_o == 1'b0, "R9 zero count no write",
            {62'd0, done_o, wr_valid_o}, 64'd0);

        // R8: misaligned start refused
        start_i = 1'b1;
        start_addr_i = 32'h0000_1002;
        byte_count_i = CW'(6);
        step();
        start_i = 1'b0;
        chk(err_o == 1'b1, "R8 error raised", 64'(err_o), 64'd1);
        for (int k = 0; k < 4; k++) begin
            byte_valid_i = 1'b1;
            wr_ready_i = 1'b1;
            #1;
            chk(!byte_ready_o && !wr_valid_o, "R8 nothing accepted or written",
                {62'd0, byte_ready_o, wr_valid_o}, 64'd0);
            step();
        end
        byte_valid_i = 1'b0;
        run_xfer(32'h3000_0004, 9, 1, 1'b0);
        chk(err_o == 1'b1, "R8 error sticky", 64'(err_o), 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule